// File: doc/BRIEF.md
# Character LCD Host Bus Front End

This block connects a host processor's parallel bus to the core of a character LCD controller. The host drives a register-select line, a read/write line and an enable strobe, and moves data over an 8-line data bus, or over its upper 4 lines only when the narrow width is selected. Each transfer is captured when the enable strobe falls. The strobe and the bus fields first pass through a synchroniser into the core clock domain.

Host writes go to one of two places. Writes with register-select low carry instruction bytes, which the block forwards to the core. Writes with register-select high carry data bytes, which go to the core's RAM. The block also holds a data register. It refills that register from the core after every address-set or cursor-move instruction and after every completed host data read, so the next read returns the data the host expects. Host reads return either a status byte, made of the busy flag and the address counter, or the data register.

The width comes up as 8 bits. A width-setting instruction changes it at run time. In the narrow width, the block joins two nibble transfers into each byte, upper nibble first, and splits reads into two nibbles in the same order.

Top module: `lcd_host_bus`

## Requirements
- R1: A write with bus_rs=0 and bus_rw=0 produces a one-cycle ins_valid pulse that carries the byte written. In 8-bit width an all-zero byte is also forwarded, and the core treats it as a no-operation.
- R2: A write with bus_rs=1 and bus_rw=0 produces a one-cycle dat_wr_valid pulse that carries the byte written, and that byte is loaded into the data register.
- R3: A read with bus_rs=0 and bus_rw=1 returns core_busy on bit 7 and core_ac on bits 6..0. The last instruction byte is never returned.
- R4: In 4-bit width only bus_d_in[7:4] is used. The first transfer supplies the upper nibble and the second the lower nibble, and exactly one byte event follows the second transfer only.
- R5: After reset the width is 8 bits. An instruction with bits 7..5 equal to 001 selects 4-bit width when bit 4 is 0 and 8-bit width when bit 4 is 1. The new width applies from the next transfer, which is treated as an upper nibble.
- R6: In 4-bit width a read takes two transfers: the upper nibble of the selected byte appears on bus_d_out[7:4] first, then the lower nibble. bus_d_out[3:0] reads 0.
- R7: In 4-bit width an instruction that assembles to 0x00 causes no ins_valid and no fetch_req, and the next transfer is again an upper nibble.
- R8: fetch_req pulses after an address-set instruction (bit 7 = 1, or bits 7..6 = 01), after a cursor-move instruction (bits 7..3 = 00010), and together with dat_rd_done after each completed data read. A data read returns the fetch_data last delivered with fetch_valid.
- R9: A data write does not request a fetch, so a data read that directly follows it returns the written byte.
- R10: bus_d_oe is high exactly while bus_en and bus_rw are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Host enable strobe; a transfer is captured on its falling edge |
| bus_rs | input | 1 | Register select: 0 selects instruction/status, 1 selects data |
| bus_rw | input | 1 | 1 = host read, 0 = host write |
| bus_d_in | input | 8 | Data bus value driven by the host |
| bus_d_out | output | 8 | Data bus value driven toward the host |
| bus_d_oe | output | 1 | Output enable for bus_d_out |
| ins_valid | output | 1 | One-cycle pulse: instruction byte ready |
| ins_byte | output | 8 | Instruction byte |
| dat_wr_valid | output | 1 | One-cycle pulse: data byte to be written to RAM |
| dat_wr_byte | output | 8 | Data byte for RAM |
| dat_rd_done | output | 1 | One-cycle pulse: host finished a data read |
| fetch_req | output | 1 | One-cycle pulse: core should deliver the next RAM byte |
| core_busy | input | 1 | Busy flag from the core |
| core_ac | input | 7 | Address counter from the core |
| fetch_valid | input | 1 | Core delivers fetch_data this cycle |
| fetch_data | input | 8 | RAM byte for the data register |

## Verification
The assertions assume that the host keeps bus_en high and then low for at least two core cycles each, and holds bus_rs, bus_rw and bus_d_in steady from before the strobe rises until a few cycles after it falls. Without that, a single transfer could produce back-to-back completions or mix fields from two transfers. The bench's transfer task sets the fields two cycles before raising the strobe, holds it high for four cycles and keeps the fields stable for eight cycles after the fall. This leaves a completed transfer, its core-side pulse and the fetch reply time to settle before the next transfer starts.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef struct packed {
    logic              rs;
    logic              rw;
    logic [BYTE_W-1:0] data;
  } bus_xfer_t;

  function automatic logic f_is_width_set(input logic [BYTE_W-1:0] b);
    return b[7:5] == 3'b001;
  endfunction

  function automatic logic f_width_bit(input logic [BYTE_W-1:0] b);
    return b[4];
  endfunction

  function automatic logic f_is_addr_set(input logic [BYTE_W-1:0] b);
    return b[7] | (b[7:6] == 2'b01);
  endfunction

  function automatic logic f_is_cursor_move(input logic [BYTE_W-1:0] b);
    return b[7:3] == 5'b00010;
  endfunction

  function automatic logic [BYTE_W-1:0] f_read_view(input logic [BYTE_W-1:0] b,
                                                    input logic narrow,
                                                    input logic low_half);
    logic [NIB_W-1:0] nib;
    nib = low_half ? b[NIB_W-1:0] : b[BYTE_W-1:NIB_W];
    return narrow ? {nib, {NIB_W{1'b0}}} : b;
  endfunction

endpackage

// File: rtl/lcd_bus_sync.sv
module lcd_bus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[i] <= '0;
          else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/lcd_bus_nibble.sv
module lcd_bus_nibble
  import lcd_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              rs,
  input  logic              rw,
  input  logic [BYTE_W-1:0] d,
  input  logic              narrow,
  input  logic              clr_phase,
  output logic              done,
  output bus_xfer_t         xfer,
  output logic              low_phase
);
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      xfer      <= '0;
      low_phase <= 1'b0;
      hi_q      <= '0;
    end else begin
      done <= 1'b0;
      if (clr_phase) begin
        low_phase <= 1'b0;
      end else if (strobe) begin
        if (!narrow) begin
          done <= 1'b1;
          xfer <= '{rs: rs, rw: rw, data: d};
        end else if (!low_phase) begin
          hi_q      <= d[BYTE_W-1:NIB_W];
          low_phase <= 1'b1;
        end else begin
          done      <= 1'b1;
          xfer      <= '{rs: rs, rw: rw, data: {hi_q, d[BYTE_W-1:NIB_W]}};
          low_phase <= 1'b0;
        end
      end
    end
  end

  AST_PHASE_ONLY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !narrow |-> !low_phase); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
endmodule

// File: rtl/lcd_bus_datareg.sv
module lcd_bus_datareg
  import lcd_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              fetch_valid,
  input  logic [BYTE_W-1:0] fetch_data,
  output logic [BYTE_W-1:0] dr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dr <= '0;
    else if (wr_en)       dr <= wr_byte;
    else if (fetch_valid) dr <= fetch_data;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dr == $past(wr_byte)); // R9
endmodule

// File: rtl/lcd_host_bus.sv
module lcd_host_bus
  import lcd_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_rs,
  input  logic       bus_rw,
  input  logic [7:0] bus_d_in,
  output logic [7:0] bus_d_out,
  output logic       bus_d_oe,
  output logic       ins_valid,
  output logic [7:0] ins_byte,
  output logic       dat_wr_valid,
  output logic [7:0] dat_wr_byte,
  output logic       dat_rd_done,
  output logic       fetch_req,
  input  logic       core_busy,
  input  logic [6:0] core_ac,
  input  logic       fetch_valid,
  input  logic [7:0] fetch_data
);
  localparam int PIN_W = BYTE_W + 3;

  logic [PIN_W-1:0] pins_s;
  logic             en_s, rs_s, rw_s, en_q;
  logic [BYTE_W-1:0] d_s;
  logic             strobe;

  lcd_bus_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bus_en, bus_rs, bus_rw, bus_d_in}),
    .q    (pins_s)
  );

  assign {en_s, rs_s, rw_s, d_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_s;

  assign strobe = en_q & ~en_s;

  // width state and nibble tracking
  logic      narrow_q;
  logic      done;
  bus_xfer_t xfer;
  logic      low_phase;
  logic      width_cmd, width_change, clr_phase;

  assign width_cmd    = done & ~xfer.rs & ~xfer.rw & f_is_width_set(xfer.data);
  assign width_change = width_cmd & (narrow_q == f_width_bit(xfer.data));
  assign clr_phase    = width_change;

  lcd_bus_nibble u_nib (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .rs       (rs_s),
    .rw       (rw_s),
    .d        (d_s),
    .narrow   (narrow_q),
    .clr_phase(clr_phase),
    .done     (done),
    .xfer     (xfer),
    .low_phase(low_phase)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          narrow_q <= 1'b0;
    else if (width_cmd)  narrow_q <= ~f_width_bit(xfer.data);

  // event decode toward the core
  logic ins_evt, wr_evt, rd_evt, zero_drop, fetch_evt;

  assign zero_drop = narrow_q & (xfer.data == '0);
  assign ins_evt   = done & ~xfer.rs & ~xfer.rw & ~zero_drop;
  assign wr_evt    = done &  xfer.rs & ~xfer.rw;
  assign rd_evt    = done &  xfer.rs &  xfer.rw;
  assign fetch_evt = rd_evt |
                     (ins_evt & (f_is_addr_set(xfer.data) | f_is_cursor_move(xfer.data)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_valid    <= 1'b0;
      ins_byte     <= '0;
      dat_wr_valid <= 1'b0;
      dat_wr_byte  <= '0;
      dat_rd_done  <= 1'b0;
      fetch_req    <= 1'b0;
    end else begin
      ins_valid    <= ins_evt;
      dat_wr_valid <= wr_evt;
      dat_rd_done  <= rd_evt;
      fetch_req    <= fetch_evt;
      if (ins_evt) ins_byte    <= xfer.data;
      if (wr_evt)  dat_wr_byte <= xfer.data;
    end
  end

  // data register and read path
  logic [BYTE_W-1:0] dr, rd_sel;

  lcd_bus_datareg u_dr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_evt),
    .wr_byte    (xfer.data),
    .fetch_valid(fetch_valid),
    .fetch_data (fetch_data),
    .dr         (dr)
  );

  assign rd_sel    = rs_s ? dr : {core_busy, core_ac};
  assign bus_d_out = f_read_view(rd_sel, narrow_q, low_phase);
  assign bus_d_oe  = bus_en & bus_rw;

  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_valid, dat_wr_valid, dat_rd_done})); // R1

  AST_READ_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd_done |-> fetch_req); // R8

  AST_WRITE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_valid |-> !fetch_req); // R9

  AST_ZERO_NIBBLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && narrow_q && $stable(narrow_q)) |-> ins_byte != 8'h00); // R7
endmodule

// File: tb/lcd_host_bus_tb.sv
`timescale 1ns/1ps
module lcd_host_bus_tb;
  localparam real CLK_P = 5.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_d_in = '0;
  logic [7:0] bus_d_out;
  logic       bus_d_oe;
  logic       ins_valid, dat_wr_valid, dat_rd_done, fetch_req;
  logic [7:0] ins_byte, dat_wr_byte;
  logic       core_busy = 1'b0;
  logic [6:0] core_ac = '0;
  logic       fetch_valid = 1'b0;
  logic [7:0] fetch_data = '0;
  logic [7:0] mem_val = '0;

  int checks = 0, failures = 0;
  int n_ins = 0, n_wr = 0, n_rd = 0, n_fetch = 0;
  logic [7:0] last_ins = '0, last_wr = '0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  lcd_host_bus u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_d_in(bus_d_in), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .ins_valid(ins_valid), .ins_byte(ins_byte), .dat_wr_valid(dat_wr_valid),
    .dat_wr_byte(dat_wr_byte), .dat_rd_done(dat_rd_done), .fetch_req(fetch_req),
    .core_busy(core_busy), .core_ac(core_ac), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data)
  );

  // core model: answer each fetch request one cycle later, count events
  always @(posedge clk) begin
    fetch_valid <= fetch_req;
    fetch_data  <= mem_val;
    if (ins_valid)    begin n_ins   <= n_ins + 1; last_ins <= ins_byte; end
    if (dat_wr_valid) begin n_wr    <= n_wr + 1;  last_wr  <= dat_wr_byte; end
    if (dat_rd_done)  n_rd    <= n_rd + 1;
    if (fetch_req)    n_fetch <= n_fetch + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d,
                      output logic [7:0] rd, output logic oe);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_d_in = d;
    repeat (2) @(negedge clk);
    bus_en = 1'b1;
    repeat (4) @(negedge clk);
    rd = bus_d_out;
    oe = bus_d_oe;
    bus_en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // stimulus table for 8-bit width: {rs, byte, exp_ins, exp_wr, exp_fetch}
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 8'h01, 3'b100},
    {1'b0, 8'h85, 3'b101},
    {1'b0, 8'h47, 3'b101},
    {1'b0, 8'h10, 3'b101},
    {1'b0, 8'h18, 3'b100},
    {1'b1, 8'h5A, 3'b010},
    {1'b0, 8'h00, 3'b100},
    {1'b0, 8'h0F, 3'b100}
  };

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    int i0, w0, f0, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    check("R10 oe idle after reset", bus_d_oe, 0);
    check("R1 no event after reset", ins_valid | dat_wr_valid | fetch_req, 0);

    // table walk in 8-bit width
    for (int k = 0; k < NVEC; k++) begin
      i0 = n_ins; w0 = n_wr; f0 = n_fetch;
      xfer(VEC[k][11], 1'b0, VEC[k][10:3], rd, oe);
      check("R1 instruction count", n_ins - i0, VEC[k][2]);
      check("R2 data write count", n_wr - w0, VEC[k][1]);
      check("R8 fetch count", n_fetch - f0, VEC[k][0]);
      if (VEC[k][2]) check("R1 instruction byte", last_ins, VEC[k][10:3]);
      if (VEC[k][1]) check("R2 data byte", last_wr, VEC[k][10:3]);
      check("R10 oe low on write", oe, 0);
    end

    // status read, instruction register not visible
    core_busy = 1'b1; core_ac = 7'h2A;
    xfer(1'b0, 1'b1, 8'h00, rd, oe);
    check("R3 status byte", rd, 8'hAA);
    check("R10 oe high on read", oe, 1);
    core_busy = 1'b0;

    // prefetch after address set and after each read
    mem_val = 8'h77;
    xfer(1'b0, 1'b0, 8'h83, rd, oe);
    mem_val = 8'h78;
    r0 = n_rd; f0 = n_fetch;
    xfer(1'b1, 1'b1, 8'h00, rd, oe);
    check("R8 read after address set", rd, 8'h77);
    check("R8 read done pulse", n_rd - r0, 1);
    check("R8 read refills", n_fetch - f0, 1);
    xfer(1'b1, 1'b1, 8'h00, rd, oe);
    check("R8 second read next byte", rd, 8'h78);

    // stale read after data write
    mem_val = 8'hEE;
    f0 = n_fetch;
    xfer(1'b1, 1'b0, 8'h3C, rd, oe);
    check("R9 write requests no fetch", n_fetch - f0, 0);
    xfer(1'b1, 1'b1, 8'h00, rd, oe);
    check("R9 read after write stale", rd, 8'h3C);

    // switch to 4-bit width
    xfer(1'b0, 1'b0, 8'h28, rd, oe);
    check("R5 width set forwarded", last_ins, 8'h28);
    i0 = n_ins;
    xfer(1'b0, 1'b0, 8'h0F, rd, oe);
    check("R4 no event after upper nibble", n_ins - i0, 0);
    xfer(1'b0, 1'b0, 8'hC5, rd, oe);
    check("R4 one event after lower nibble", n_ins - i0, 1);
    check("R4 assembled byte", last_ins, 8'h0C);

    // 4-bit status read
    core_ac = 7'h35;
    xfer(1'b0, 1'b1, 8'h00, rd, oe);
    check("R6 status upper nibble", rd, 8'h30);
    xfer(1'b0, 1'b1, 8'h00, rd, oe);
    check("R6 status lower nibble", rd, 8'h50);

    // reserved all-zero code in 4-bit width
    i0 = n_ins; f0 = n_fetch;
    xfer(1'b0, 1'b0, 8'h00, rd, oe);
    xfer(1'b0, 1'b0, 8'h00, rd, oe);
    check("R7 zero code no instruction", n_ins - i0, 0);
    check("R7 zero code no fetch", n_fetch - f0, 0);
    xfer(1'b0, 1'b0, 8'h00, rd, oe);
    xfer(1'b0, 1'b0, 8'h10, rd, oe);
    check("R7 phase back to upper", last_ins, 8'h01);

    // 4-bit data read
    mem_val = 8'h9C;
    xfer(1'b0, 1'b0, 8'h80, rd, oe);
    xfer(1'b0, 1'b0, 8'h40, rd, oe);
    check("R8 narrow address set", last_ins, 8'h84);
    r0 = n_rd;
    xfer(1'b1, 1'b1, 8'h00, rd, oe);
    check("R6 data upper nibble", rd, 8'h90);
    check("R6 no read done yet", n_rd - r0, 0);
    xfer(1'b1, 1'b1, 8'h00, rd, oe);
    check("R6 data lower nibble", rd, 8'hC0);
    check("R8 read done after both", n_rd - r0, 1);

    // back to 8-bit width
    xfer(1'b0, 1'b0, 8'h30, rd, oe);
    xfer(1'b0, 1'b0, 8'h00, rd, oe);
    check("R5 width set back to 8", last_ins, 8'h30);
    xfer(1'b1, 1'b0, 8'hA5, rd, oe);
    check("R5 full byte after widening", last_wr, 8'hA5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule